// File: doc/BRIEF.md
# Implication Checker with Dual-Rail Error Output

This block watches a combinational control circuit while it runs. Every clock it takes the circuit's input vector and output vector and tests them against a fixed set of implication rules. Each rule names a partial input pattern (a care mask plus the required values on the cared bits) and one output bit with the value that output must carry whenever the pattern is present. A rule can fail only when its pattern is present and the named output has the wrong value. The checker as a whole is the AND of all rules, so any one failing rule raises the error.

The error indication is a registered two-wire code. The wires carry opposite values while every rule holds. They carry equal values when a rule fails. One wire flips on every clock even when no error is present, so a wire stuck at a constant level shows up as an invalid code within two cycles.

A self-exercising test mode is started with a one-cycle pulse. In this mode a small sequencer forces every pattern to count as present. It then forces the required value of one rule at a time to be wrong, one rule per cycle. It confirms that exactly the expected rule, and no other, reports a failure. At the end it raises a done flag together with a pass/fail result. The rules are supplied as parameters; nothing in the block chooses or changes them at run time.

Top module: `ced_checker`

## Requirements
- R1: A rule's pattern is present when every input bit set in its care mask equals the matching bit of its value pattern. Input bits outside the care mask have no effect on the rule.
- R2: A rule fails when its pattern is present and its output bit differs from its required polarity. The default rules are: rule0 {in2=1, in3=0} requires out5=1; rule1 {in0=0} requires out0=0; rule2 {in4=1, in5=1} requires out2=1; rule3 {in7=1} requires out3=0.
- R3: A rule whose pattern is absent never fails, whatever the output vector holds.
- R4: The error is the OR of all rule failures. One failing rule or several failing rules give the same error indication.
- R5: While the input and output vectors of clock N satisfy every rule, `err_rail` after edge N holds unequal bits (01 or 10). If any rule fails in clock N, `err_rail` after edge N holds equal bits (00 or 11).
- R6: `err_rail[0]` inverts on every clock edge once internal reset has been released.
- R7: While reset is held, `err_rail` reads 2'b10 and `test_done` and `test_fail` read 0. The reset is applied asynchronously and released through a two-stage synchronizer.
- R8: A `test_start` pulse seen while no test is running starts the test. For the next N_ASRT edges `err_rail` shows the error code. `test_done` rises on the N_ASRT-th edge after the start edge. `test_fail` is 0 on a correct checker and is 1 if any step shows a failure vector other than the single expected rule.
- R9: While a test runs, `test_start`, `in_vec` and `out_vec` have no effect on the sequence or on its timing.
- R10: After a test, the checker returns to normal checking. `test_done` and `test_fail` hold their values until the next `test_start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| test_start | input | 1 | One-cycle pulse that starts the self-exercising test |
| in_vec | input | IN_W | Input vector of the protected circuit |
| out_vec | input | OUT_W | Output vector of the protected circuit |
| err_rail | output | 2 | Two-wire error code: unequal means no error, equal means error |
| test_done | output | 1 | High once the self-exercising test has finished |
| test_fail | output | 1 | Result of the last test, valid while test_done is high |

## Verification
Directed vectors separate the cases that matter for a single rule: pattern present with a correct output, pattern present with a wrong output, pattern absent with outputs that would be wrong, and patterns that differ only in don't-care bits. Vectors that break several rules at once show that the OR does not cancel or mask. Several thousand random input/output pairs then cover the rule set broadly against a bench model of the rules, and every cycle also checks that the alternating wire keeps flipping. Test runs are made cleanly, with a stray start pulse inside the run, and back to back, so that the cycle of `test_done`, the forced error code and the return to normal checking are all pinned.

// File: rtl/ced_pkg.sv
`timescale 1ns/1ps
package ced_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ced_rst_sync.sv
`timescale 1ns/1ps
module ced_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ced_asrt_eval.sv
`timescale 1ns/1ps
module ced_asrt_eval #(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 6,
  parameter int N_ASRT = 4,
  parameter int IDX_W  = 3,
  parameter logic [N_ASRT*IN_W-1:0]  CARE = '0,
  parameter logic [N_ASRT*IN_W-1:0]  PAT  = '0,
  parameter logic [N_ASRT*IDX_W-1:0] OIDX = '0,
  parameter logic [N_ASRT-1:0]       OPOL = '0
) (
  input  logic [IN_W-1:0]   in_vec,
  input  logic [OUT_W-1:0]  out_vec,
  input  logic              force_en,
  input  logic [N_ASRT-1:0] force_sel,
  output logic [N_ASRT-1:0] viol
);
  for (genvar i = 0; i < N_ASRT; i++) begin : g_rule
    localparam logic [IN_W-1:0]  CARE_I = CARE[i*IN_W +: IN_W];
    localparam logic [IN_W-1:0]  PAT_I  = PAT[i*IN_W +: IN_W];
    localparam logic [IDX_W-1:0] OIDX_I = OIDX[i*IDX_W +: IDX_W];
    logic hit;
    logic cons_ok;
    always_comb begin
      hit     = force_en | (((in_vec ^ PAT_I) & CARE_I) == '0);
      cons_ok = force_en ? ~force_sel[i] : (out_vec[OIDX_I] == OPOL[i]);
      viol[i] = hit & ~cons_ok;
    end
  end
endmodule

// File: rtl/ced_dual_rail.sv
`timescale 1ns/1ps
module ced_dual_rail #(
  parameter int N_ASRT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ASRT-1:0] viol,
  output logic [1:0]        err_rail
);
  logic       phase_q, phase_d;
  logic [1:0] rail_q, rail_d;
  logic       any_viol;

  always_comb begin
    any_viol = |viol;
    phase_d  = ~phase_q;
    rail_d   = {phase_q ^ any_viol, ~phase_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      rail_q  <= 2'b10;
    end else begin
      phase_q <= phase_d;
      rail_q  <= rail_d;
    end
  end

  assign err_rail = rail_q;
endmodule

// File: rtl/ced_test_seq.sv
`timescale 1ns/1ps
module ced_test_seq
  import ced_pkg::*;
#(
  parameter int N_ASRT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_start,
  input  logic [N_ASRT-1:0] viol,
  output logic              force_en,
  output logic [N_ASRT-1:0] force_sel,
  output logic              test_done,
  output logic              test_fail
);
  localparam int SEL_W = (N_ASRT > 1) ? $clog2(N_ASRT) : 1;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_ASRT - 1);

  seq_state_t       state_q, state_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic             fail_q, fail_d;
  logic             done_q, done_d;
  logic             step_en;

  for (genvar i = 0; i < N_ASRT; i++) begin : g_sel
    localparam logic [SEL_W-1:0] POS = SEL_W'(i);
    assign force_sel[i] = force_en & (idx_q == POS);
  end

  always_comb begin
    force_en = (state_q == SEQ_RUN);
    state_d  = state_q;
    idx_d    = idx_q;
    fail_d   = fail_q;
    done_d   = done_q;
    step_en  = 1'b0;
    case (state_q)
      SEQ_RUN: begin
        step_en = 1'b1;
        if (viol != force_sel) fail_d = 1'b1;
        if (idx_q == LAST) begin
          state_d = SEQ_DONE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + SEL_W'(1);
        end
      end
      default: begin
        if (test_start) begin
          step_en = 1'b1;
          state_d = SEQ_RUN;
          idx_d   = '0;
          fail_d  = 1'b0;
          done_d  = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (step_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  assign test_done = done_q;
  assign test_fail = fail_q;
endmodule

// File: rtl/ced_checker.sv
`timescale 1ns/1ps
module ced_checker #(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 6,
  parameter int N_ASRT = 4,
  parameter int IDX_W  = (OUT_W > 1) ? $clog2(OUT_W) : 1,
  parameter logic [N_ASRT*IN_W-1:0]  CARE = 32'h8030_010C,
  parameter logic [N_ASRT*IN_W-1:0]  PAT  = 32'h8030_0004,
  parameter logic [N_ASRT*IDX_W-1:0] OIDX = 12'h685,
  parameter logic [N_ASRT-1:0]       OPOL = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_start,
  input  logic [IN_W-1:0]  in_vec,
  input  logic [OUT_W-1:0] out_vec,
  output logic [1:0]       err_rail,
  output logic             test_done,
  output logic             test_fail
);
  logic              rst_n_int;
  logic              busy;
  logic [N_ASRT-1:0] force_sel;
  logic [N_ASRT-1:0] viol_vec;

  ced_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ced_asrt_eval #(
    .IN_W(IN_W), .OUT_W(OUT_W), .N_ASRT(N_ASRT), .IDX_W(IDX_W),
    .CARE(CARE), .PAT(PAT), .OIDX(OIDX), .OPOL(OPOL)
  ) u_eval (
    .in_vec    (in_vec),
    .out_vec   (out_vec),
    .force_en  (busy),
    .force_sel (force_sel),
    .viol      (viol_vec)
  );

  ced_dual_rail #(.N_ASRT(N_ASRT)) u_rail (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .viol     (viol_vec),
    .err_rail (err_rail)
  );

  ced_test_seq #(.N_ASRT(N_ASRT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .test_start (test_start),
    .viol       (viol_vec),
    .force_en   (busy),
    .force_sel  (force_sel),
    .test_done  (test_done),
    .test_fail  (test_fail)
  );
endmodule

// File: rtl/ced_checker_sva.sv
`timescale 1ns/1ps
module ced_checker_sva #(
  parameter int N_ASRT = 4
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              test_start,
  input logic              busy,
  input logic [N_ASRT-1:0] viol_vec,
  input logic [1:0]        err_rail,
  input logic              test_done,
  input logic              test_fail
);
  assert_fail_flags_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|viol_vec) |=> (err_rail[1] == err_rail[0]));

  assert_clean_code_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(|viol_vec) |=> (err_rail[1] != err_rail[0]));

  assert_rail_flips_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    1'b1 |=> (err_rail[0] != $past(err_rail[0])));

  assert_one_rule_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy |-> ($countones(viol_vec) == 1));

  assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!busy && test_start) |=> (busy && !test_done));

  assert_clean_result_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(test_done) |-> !test_fail);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (test_done && !test_start) |=> (test_done && $stable(test_fail)));
endmodule

bind ced_checker ced_checker_sva #(.N_ASRT(N_ASRT)) u_sva (
  .clk        (clk),
  .rst_n_int  (rst_n_int),
  .test_start (test_start),
  .busy       (busy),
  .viol_vec   (viol_vec),
  .err_rail   (err_rail),
  .test_done  (test_done),
  .test_fail  (test_fail)
);

// File: tb/ced_checker_tb.sv
`timescale 1ns/1ps
module ced_checker_tb_top;
  localparam int NA = 4;

  logic       clk;
  logic       rst_n;
  logic       test_start;
  logic [7:0] in_vec;
  logic [5:0] out_vec;
  logic [1:0] err_rail;
  logic       test_done;
  logic       test_fail;

  int checks   = 0;
  int failures = 0;
  logic prev_r0;

  ced_checker dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_start (test_start),
    .in_vec     (in_vec),
    .out_vec    (out_vec),
    .err_rail   (err_rail),
    .test_done  (test_done),
    .test_fail  (test_fail)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Rule model built from the requirement text (R1, R2, R3)
  function automatic logic [3:0] model_viol(input logic [7:0] iv, input logic [5:0] ov);
    logic [3:0] v;
    v[0] = (iv[2] == 1'b1 && iv[3] == 1'b0) && (ov[5] != 1'b1);
    v[1] = (iv[0] == 1'b0) && (ov[0] != 1'b0);
    v[2] = (iv[4] == 1'b1 && iv[5] == 1'b1) && (ov[2] != 1'b1);
    v[3] = (iv[7] == 1'b1) && (ov[3] != 1'b0);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One normal cycle: drive, pass one edge, compare the code and the flip
  task automatic cycle_check(input logic [7:0] iv, input logic [5:0] ov, input string req);
    logic [3:0] v;
    @(negedge clk);
    in_vec  = iv;
    out_vec = ov;
    v = model_viol(iv, ov);
    @(posedge clk);
    #1;
    check((err_rail[1] == err_rail[0]) == (v != 4'd0), req, "error code",
          int'(err_rail), (v != 4'd0) ? 1 : 0);
    check(err_rail[0] != prev_r0, "R6", "rail flip", int'(err_rail[0]), int'(~prev_r0));
    prev_r0 = err_rail[0];
  endtask

  task automatic run_test(input bit stray_start);
    @(negedge clk);
    test_start = 1'b1;
    @(posedge clk);
    #1;
    prev_r0 = err_rail[0];
    for (int k = 1; k <= NA; k++) begin
      @(negedge clk);
      test_start = stray_start && (k == 2);
      in_vec  = 8'($urandom);
      out_vec = 6'($urandom);
      @(posedge clk);
      #1;
      check(err_rail[1] == err_rail[0], "R8", "forced error code", int'(err_rail), 0);
      check(err_rail[0] != prev_r0, "R6", "rail flip in test", int'(err_rail[0]), int'(~prev_r0));
      prev_r0 = err_rail[0];
      check(test_done == (k == NA), stray_start ? "R9" : "R8", "done timing",
            int'(test_done), (k == NA) ? 1 : 0);
    end
    check(test_fail == 1'b0, "R8", "test result", int'(test_fail), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n      = 1'b0;
    test_start = 1'b0;
    in_vec     = '0;
    out_vec    = '0;
    repeat (3) @(negedge clk);
    check(err_rail == 2'b10, "R7", "reset code", int'(err_rail), 2);
    check(test_done == 1'b0, "R7", "reset done", int'(test_done), 0);
    check(test_fail == 1'b0, "R7", "reset fail", int'(test_fail), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    prev_r0 = err_rail[0];

    // Directed corner cases
    cycle_check(8'h04, 6'h00, "R2");  // rule0 present, out5 wrong
    cycle_check(8'h44, 6'h00, "R1");  // in6 is don't-care for rule0
    cycle_check(8'h0C, 6'h00, "R3");  // rule0 absent (in3=1)
    cycle_check(8'h0E, 6'h3F, "R3");  // rule0 absent, wrong-looking outputs except rule1
    cycle_check(8'h05, 6'h20, "R2");  // rule0 satisfied, rule1 absent
    cycle_check(8'h31, 6'h00, "R2");  // rule2 present, out2 wrong
    cycle_check(8'h81, 6'h08, "R4");  // only rule3 fails
    cycle_check(8'hB5, 6'h08, "R4");  // rules 0, 2, 3 fail together
    cycle_check(8'hB5, 6'h24, "R5");  // all present rules satisfied
    cycle_check(8'h00, 6'h01, "R4");  // rule1 fails alone

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      cycle_check(8'($urandom), 6'($urandom), "R5");
    end

    // Self-exercising test, clean run
    run_test(1'b0);
    cycle_check(8'h05, 6'h20, "R10");
    check(test_done == 1'b1, "R10", "done held", int'(test_done), 1);
    cycle_check(8'h04, 6'h00, "R10");
    check(test_fail == 1'b0, "R10", "fail held", int'(test_fail), 0);

    // Run with a stray start pulse mid-sequence, then back to back
    run_test(1'b1);
    run_test(1'b0);
    cycle_check(8'h31, 6'h00, "R10");
    for (int n = 0; n < 200; n++) begin
      cycle_check(8'($urandom), 6'($urandom), "R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule